// File: doc/BRIEF.md
# Millisecond-Window Pin Debounce Filter

This block cleans up one slow external input before it reaches the input-status and edge-detection logic of a general-purpose pin. The raw pin is first brought into the system clock domain by a short synchronizer chain. A small state machine then decides whether a level change on the synchronized pin is genuine. A change counts as genuine only when the new level has held, without interruption, for a window measured in milliseconds. The filtered level is the block's only output.

Two control bits come straight from the pin's control word. The enable bit is bit 8 of that word. The 3-bit range code is bits [7:5] of that word. The window is 2^code milliseconds, so the code covers 1 ms to 128 ms. The millisecond time base comes from a prescaler that divides the system clock by the parameter `CLKS_PER_MS`. The prescaler restarts each time a count begins, so a window is always exactly 2^code × `CLKS_PER_MS` clock cycles long.

The state machine has three states:
- `ST_BYPASS`: the filter is disabled and the output follows the synchronized pin.
- `ST_IDLE`: the output matches the synchronized pin and the counters are cleared.
- `ST_COUNT`: the pin differs from the output and the window is being timed.

The transitions are:
- Arm: `ST_BYPASS` to `ST_IDLE` when the enable bit rises.
- Disarm: any state to `ST_BYPASS` when the enable bit falls.
- Start: `ST_IDLE` to `ST_COUNT` when the pin differs from the output.
- Cancel: `ST_COUNT` to `ST_IDLE` when the pin returns to the output level.
- Accept: `ST_COUNT` to `ST_IDLE` when the window expires; the output takes the new level.
- Restart: `ST_COUNT` to `ST_COUNT` when the code or the enable bit changes; the counters are cleared and the output holds.

Top module: `pin_debounce`

## Requirements
- R1: While reset (rst_n low, sampled synchronously) is applied, the filtered output loads the synchronized pin level. In the first cycle after reset is released, it therefore equals the pin level that was held during reset.
- R2: With the enable bit (control-word bit 8) at 0, the output follows the pin with no filtering. The latency is exactly 3 clock edges: two synchronizer stages plus the output register. This also holds when the filter is disabled in the middle of a count.
- R3: With the enable bit at 1 and range code n (control-word bits [7:5], 0 to 7), an accepted change appears exactly 3 + 2^n × CLKS_PER_MS clock edges after the pin changes. This gives windows of 1 ms (code 0) up to 128 ms (code 7).
- R4: Rising and falling pin changes are filtered the same way, with the same window.
- R5: With the enable bit at 1, a pin pulse held for at most 2^n × CLKS_PER_MS clock cycles never reaches the output. A pulse held one cycle longer does reach it.
- R6: A change of the range code or the enable bit while a count is running restarts the window under the new setting. The filtered output holds its value on the clock edge where the change is seen.
- R7: The millisecond tick fires once every CLKS_PER_MS cycles of an uninterrupted count. The prescaler count never exceeds CLKS_PER_MS − 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Raw, asynchronous pin level |
| db_enable | input | 1 | Debounce enable (control-word bit 8) |
| db_range | input | RANGE_W | Window code n, window = 2^n ms (control-word bits [7:5]) |
| pin_filtered | output | 1 | Debounced pin level |

## Verification
The hardest situation to reach from the ports is a setting change that lands in the middle of a running count. The change must arrive late enough that the original window would already have expired before the restarted one. Only then does a restart look different from no restart. The bench starts a count with a 16-cycle window. It switches to an 8-cycle window twelve edges in, so an accepted change at edge 19 (no restart) and at edge 21 (restart) are told apart. A second case turns the filter off mid-count and expects the output to follow the pin on the very next edge. The pulse-length boundary is also swept just below and just at the window for several codes.

// File: rtl/pin_debounce_pkg.sv
`timescale 1ns/1ps
package pin_debounce_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_IDLE   = 2'd1,
        ST_COUNT  = 2'd2
    } db_state_t;

endpackage

// File: rtl/db_sync.sv
`timescale 1ns/1ps
module db_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) chain[0] <= d_in;
        end else begin : g_many
            always_ff @(posedge clk) chain <= {chain[STAGES-2:0], d_in};
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/db_ms_prescaler.sv
`timescale 1ns/1ps
module db_ms_prescaler #(
    parameter int CLKS_PER_MS = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);

    // R7: prescaler never passes its terminal value
    a_r7_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7: an uninterrupted count advances by one each cycle
    a_r7_pre_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && $past(rst_n) && $past(cnt) != LAST) |-> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/db_filter_fsm.sv
`timescale 1ns/1ps
module db_filter_fsm
    import pin_debounce_pkg::*;
#(
    parameter int RANGE_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_pin,
    input  logic               en,
    input  logic [RANGE_W-1:0] code,
    input  logic               tick,
    output logic               run,
    output logic               filt
);
    localparam int MS_W = (1 << RANGE_W) - 1;

    db_state_t          state_q, state_d;
    logic [MS_W-1:0]    ms_cnt;
    logic [MS_W:0]      win_full;
    logic [MS_W-1:0]    win_m1;
    logic [RANGE_W:0]   cfg_q;
    logic               cfg_chg;
    logic               differs;
    logic               accept;

    assign win_full = (MS_W+1)'(1) << code;
    assign win_m1   = MS_W'(win_full - 1'b1);
    assign cfg_chg  = ({en, code} != cfg_q);
    assign differs  = (sync_pin != filt);
    assign run      = (state_q == ST_COUNT) && en && differs && !cfg_chg;
    assign accept   = tick && (ms_cnt == win_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= {en, code};
        else        cfg_q <= {en, code};
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BYPASS: if (en)       state_d = ST_IDLE;      // arm
            ST_IDLE: begin
                if (!en)             state_d = ST_BYPASS;    // disarm
                else if (differs)    state_d = ST_COUNT;     // start
            end
            ST_COUNT: begin
                if (!en)             state_d = ST_BYPASS;    // disarm
                else if (!differs)   state_d = ST_IDLE;      // cancel
                else if (accept)     state_d = ST_IDLE;      // accept
                else                 state_d = ST_COUNT;     // keep / restart
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Millisecond counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  ms_cnt <= '0;
        else if (tick)       ms_cnt <= accept ? '0 : ms_cnt + 1'b1;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)      filt <= sync_pin;
        else if (!en)    filt <= sync_pin;
        else if (accept) filt <= sync_pin;
    end

    // R2: disabled filter copies the synchronized pin on the next edge
    a_r2_bypass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (filt == $past(sync_pin)));

    // R3: while enabled, the output moves only on a millisecond tick
    a_r3_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(rst_n) && filt != $past(filt)) |-> $past(tick));

    // R3: the millisecond count stays inside the selected window
    a_r3_ms_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && en && !cfg_chg) |-> (ms_cnt <= win_m1));

    // R6: a setting change while enabled holds the output and clears the count
    a_r6_hold_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg_q[RANGE_W] && cfg_chg) |=> ($stable(filt) && ms_cnt == '0));
endmodule

// File: rtl/pin_debounce.sv
`timescale 1ns/1ps
module pin_debounce #(
    parameter int CLKS_PER_MS = 100000,
    parameter int RANGE_W     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pin_in,
    input  logic               db_enable,
    input  logic [RANGE_W-1:0] db_range,
    output logic               pin_filtered
);
    logic pin_s;
    logic ms_tick;
    logic ms_run;

    db_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .d_in  (pin_in),
        .q_out (pin_s)
    );

    db_ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ms_run),
        .tick  (ms_tick)
    );

    db_filter_fsm #(.RANGE_W(RANGE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_pin (pin_s),
        .en       (db_enable),
        .code     (db_range),
        .tick     (ms_tick),
        .run      (ms_run),
        .filt     (pin_filtered)
    );
endmodule

// File: tb/pin_debounce_tb.sv
`timescale 1ns/1ps
module pin_debounce_tb;
    localparam int C = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_in = 1'b0;
    logic       db_enable = 1'b1;
    logic [2:0] db_range = 3'd0;
    logic       pin_filtered;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pin_debounce #(.CLKS_PER_MS(C), .RANGE_W(3), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .db_enable(db_enable), .db_range(db_range),
        .pin_filtered(pin_filtered)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive pin to lvl at a negedge, count edges until the output follows
    task automatic latency(input logic lvl, input int exp, input string tag);
        int n = 0;
        @(negedge clk);
        pin_in = lvl;
        while (pin_filtered != lvl && n < exp + 40) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(n == exp, tag, n, exp);
    endtask

    // Pulse of len cycles from a low resting level; report whether output rose
    task automatic pulse(input int len, input int watch, output bit rose);
        rose = 1'b0;
        @(negedge clk);
        pin_in = 1'b1;
        for (int i = 0; i < watch; i++) begin
            if (i == len) pin_in = 1'b0;
            @(posedge clk);
            #1;
            if (pin_filtered) rose = 1'b1;
            @(negedge clk);
        end
        pin_in = 1'b0;
    endtask

    task automatic do_reset(input logic lvl);
        @(negedge clk);
        rst_n = 1'b0;
        pin_in = lvl;
        settle(6);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit rose;
        int n;

        // R1: reset with pin low, then pin high
        do_reset(1'b0);
        check(pin_filtered == 1'b0, "R1 reset low", pin_filtered, 0);
        do_reset(1'b1);
        check(pin_filtered == 1'b1, "R1 reset high", pin_filtered, 1);
        settle(3);
        check(pin_filtered == 1'b1, "R1 no spurious count", pin_filtered, 1);
        do_reset(1'b0);

        // R3 / R4: sweep every code, rising then falling
        for (int code = 0; code < 8; code++) begin
            db_range = 3'(code);
            settle(3);
            latency(1'b1, 3 + (1 << code) * C, $sformatf("R3 R4 rise code %0d", code));
            settle(3);
            latency(1'b0, 3 + (1 << code) * C, $sformatf("R3 R4 fall code %0d", code));
            settle(3);
        end

        // R7: window of code 1 equals exactly two prescaler periods
        db_range = 3'd1;
        settle(3);
        latency(1'b1, 3 + 2 * C, "R7 tick period");
        settle(3);
        latency(1'b0, 3 + 2 * C, "R7 tick period fall");

        // R5: pulse boundary for codes 0..3
        for (int code = 0; code < 4; code++) begin
            db_range = 3'(code);
            settle(3);
            pulse((1 << code) * C, (1 << code) * C + 12, rose);
            check(!rose, $sformatf("R5 reject len=window code %0d", code), rose, 0);
            settle((1 << code) * C + 8);
            pulse((1 << code) * C + 1, (1 << code) * C + 12, rose);
            check(rose, $sformatf("R5 accept len=window+1 code %0d", code), rose, 1);
            settle(2 * (1 << code) * C + 12);
            check(pin_filtered == 1'b0, $sformatf("R5 settles low code %0d", code), pin_filtered, 0);
        end

        // R2: bypass both directions
        db_enable = 1'b0;
        settle(4);
        latency(1'b1, 3, "R2 bypass rise");
        latency(1'b0, 3, "R2 bypass fall");
        db_enable = 1'b1;
        settle(4);
        check(pin_filtered == 1'b0, "R2 arm holds", pin_filtered, 0);

        // R6: code change mid-count restarts with new window
        db_range = 3'd2;
        settle(3);
        @(negedge clk);
        pin_in = 1'b1;
        n = 0;
        repeat (12) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(pin_filtered == 1'b0, "R6 held before change", pin_filtered, 0);
        @(negedge clk);
        db_range = 3'd1;
        while (pin_filtered != 1'b1 && n < 80) begin
            @(posedge clk);
            #1;
            n++;
        end
        check(n == 21, "R6 restart latency", n, 21);
        settle(3);
        latency(1'b0, 3 + 2 * C, "R6 new window kept");

        // R2: disable in the middle of a count
        db_range = 3'd3;
        settle(3);
        @(negedge clk);
        pin_in = 1'b1;
        n = 0;
        repeat (5) begin
            @(posedge clk);
            #1;
            n++;
        end
        @(negedge clk);
        db_enable = 1'b0;
        @(posedge clk);
        #1;
        n++;
        check(pin_filtered == 1'b1 && n == 6, "R2 disable mid-count", pin_filtered, 1);

        // R6: re-enable holds output
        @(negedge clk);
        pin_in = 1'b0;
        db_enable = 1'b1;
        settle(6);
        check(pin_filtered == 1'b1, "R6 enable holds", pin_filtered, 1);
        settle(8 * C + 4);
        check(pin_filtered == 1'b0, "R6 enable then window", pin_filtered, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule